// File: doc/BRIEF.md
# OUT Endpoint Receive DMA

This block drains received OUT packets from a receive FIFO of 32-bit words and writes them into system memory through a word-wide write port with a ready stall. It works under one of two buffer disciplines. In per-packet mode each packet takes a fresh descriptor from a chain, so every packet lands at its own address (scatter-gather). In fill mode one descriptor names a large buffer and packets are packed into it word after word until a short packet closes it.

Descriptors are supplied on a request/acknowledge port that returns a buffer address and an end-of-chain flag. When a buffer is closed the block emits a one-cycle status writeback: the descriptor's buffer address, the byte count, and an error flag. An interrupt pulse comes in the same cycle. Transfers start either when a whole packet sits in the FIFO, or, with early start enabled, once the FIFO holds a programmed number of words. Under early start the packet has not yet been validated when its first words are written.

The controller has four states. `ST_IDLE` waits for the start condition and goes to `ST_FETCH` when no descriptor is held, or straight to `ST_XFER` when one is held. `ST_FETCH` holds the request until acknowledge and then enters `ST_XFER`. `ST_XFER` moves words. At the final word of a packet it enters `ST_WBACK` when a writeback is due, and returns to `ST_IDLE` otherwise. `ST_WBACK` lasts one cycle and returns to `ST_IDLE`.

Top module: `out_rx_dma`

## Requirements
- R1: While reset is asserted, and afterwards until a start condition occurs, `desc_req`, `mem_wr`, `rx_pop`, `wb_valid` and `irq` are 0.
- R2: In per-packet mode (`cfg_bufmode`=0) each packet takes one new descriptor. Its words are written starting at that descriptor's `desc_addr`, and the address rises by 4 per written word.
- R3: In per-packet mode with `cfg_upd_each`=1, a writeback follows every packet. `wb_bytes` is that packet's byte count, `wb_buf` is its descriptor address, and `irq` is high in the same cycle.
- R4: In per-packet mode with `cfg_upd_each`=0, a writeback occurs only after the packet that used a descriptor whose `desc_last`=1. `wb_bytes` is then the sum of the byte counts over the chain, and `wb_buf` is the last descriptor's address.
- R5: In fill mode (`cfg_bufmode`=1) packets are written one after another into the single buffer. A packet whose last word is partial still advances the address by a full word. A packet of exactly `cfg_max_pkt` bytes produces no writeback.
- R6: In fill mode a short packet closes the buffer. A short packet has fewer bytes than `cfg_max_pkt`, and a zero-length packet counts as short. The writeback carries the total bytes since the buffer opened, with `irq` in the same cycle. The next packet fetches a new descriptor.
- R7: With `cfg_thr_en`=0 no word is popped or written until `rx_pkt_ready` shows a whole packet in the FIFO.
- R8: With `cfg_thr_en`=1, transfer begins once `rx_level` is nonzero and at least `cfg_thr_len`, before the packet is complete.
- R9: If the final word of any packet in the closing buffer carries `rx_err`=1, then `wb_err`=1 on that writeback. Otherwise `wb_err`=0.
- R10: While `mem_wr`=1 and `mem_ready`=0, `mem_wr` stays high with a stable address and data, and no word is lost or repeated.
- R11: `desc_req` stays high until `desc_ack`. `wb_valid` is a single-cycle pulse, raised in the cycle after the final word of a packet is popped.
- R12: A zero-length packet is one FIFO word with `rx_last`=1 and `rx_lastbytes`=0. It is popped without a memory write and adds 0 bytes. For other last words, `rx_lastbytes` (1..4) gives the valid byte count; every non-last word counts 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bufmode | input | 1 | 1 = fill mode, 0 = per-packet mode |
| cfg_upd_each | input | 1 | Per-packet mode: write back after every packet |
| cfg_thr_en | input | 1 | Early start enable |
| cfg_thr_len | input | 8 | Early start level in words |
| cfg_max_pkt | input | MPW | Maximum packet size in bytes |
| desc_req | output | 1 | Descriptor request |
| desc_ack | input | 1 | Descriptor returned |
| desc_addr | input | AW | Buffer address of returned descriptor |
| desc_last | input | 1 | Returned descriptor ends its chain |
| rx_valid | input | 1 | FIFO head word present |
| rx_data | input | 32 | FIFO head word |
| rx_last | input | 1 | Head word ends a packet |
| rx_lastbytes | input | 3 | Valid bytes in a last word (0 = zero-length packet) |
| rx_err | input | 1 | Packet error flag, valid with rx_last |
| rx_level | input | LW | Words held in FIFO |
| rx_pkt_ready | input | 1 | At least one whole packet is in FIFO |
| rx_pop | output | 1 | Pop FIFO head |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts write |
| wb_valid | output | 1 | Status writeback strobe |
| wb_buf | output | AW | Address of descriptor written back |
| wb_bytes | output | BCW | Byte count written back |
| wb_err | output | 1 | Error status written back |
| irq | output | 1 | Interrupt pulse |

## Verification
Zero-length packets are mixed in with partial last words. A design that wrote the marker word or miscounted tail bytes would show a stray memory write or a wrong byte total. Fill-mode runs chain full-size packets before a short one. A design that closed the buffer early, restarted the address, or failed to fetch afresh afterwards would write to wrong addresses. Split pushes hold back the tail of a packet with early start off and on. This exposes a design that starts before the packet is whole, or one that waits despite the level. An errored tail after an early start must show in the status. Random memory stalls catch words that are dropped or repeated under backpressure.

// File: rtl/out_rx_dma_pkg.sv
package out_rx_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_WBACK
    } dma_state_t;

    localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/out_rx_dma_gate.sv
module out_rx_dma_gate #(
    parameter int LW = 8,
    parameter int TW = 8
) (
    input  logic          thr_en,
    input  logic [TW-1:0] thr_len,
    input  logic [LW-1:0] rx_level,
    input  logic          rx_pkt_ready,
    output logic          go
);
    localparam int CW = (LW > TW) ? LW : TW;

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] thr_x;
    logic          early;

    always_comb begin
        lvl_x = CW'(rx_level);
        thr_x = CW'(thr_len);
        // early start needs at least one word and the programmed level
        early = thr_en && (lvl_x != '0) && (lvl_x >= thr_x);
        go    = rx_pkt_ready || early;
    end
endmodule

// File: rtl/out_rx_dma_acct.sv
module out_rx_dma_acct
    import out_rx_dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int BCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  load_addr,
    input  logic           beat,
    input  logic           beat_last,
    input  logic [2:0]     beat_lb,
    input  logic           beat_err,
    input  logic           clr,
    output logic [AW-1:0]  wr_addr,
    output logic [BCW-1:0] acc_bytes,
    output logic [BCW-1:0] pkt_total,
    output logic           err_acc
);
    logic [BCW-1:0] pkt_bytes;
    logic [BCW-1:0] beat_bytes;
    logic           beat_writes;

    always_comb begin
        beat_bytes  = beat_last ? BCW'(beat_lb) : BCW'(WORD_BYTES);
        beat_writes = !(beat_last && (beat_lb == 3'd0));
        pkt_total   = pkt_bytes + beat_bytes;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
        end else if (load) begin
            wr_addr <= load_addr;
        end else if (beat && beat_writes) begin
            wr_addr <= wr_addr + AW'(WORD_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_bytes <= '0;
        end else if (beat) begin
            pkt_bytes <= beat_last ? '0 : pkt_total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_bytes <= '0;
            err_acc   <= 1'b0;
        end else if (clr) begin
            acc_bytes <= '0;
            err_acc   <= 1'b0;
        end else if (beat) begin
            acc_bytes <= acc_bytes + beat_bytes;
            if (beat_last && beat_err) begin
                err_acc <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/out_rx_dma_fsm.sv
module out_rx_dma_fsm
    import out_rx_dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int BCW = 16,
    parameter int MPW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_bf,
    input  logic           upd_each,
    input  logic           go,
    input  logic           desc_ack,
    input  logic [AW-1:0]  desc_addr,
    input  logic           desc_last,
    input  logic           rx_valid,
    input  logic           rx_last,
    input  logic [2:0]     rx_lastbytes,
    input  logic           mem_ready,
    input  logic [BCW-1:0] pkt_total,
    input  logic [MPW-1:0] max_pkt,
    output logic           desc_req,
    output logic           desc_load,
    output logic           rx_pop,
    output logic           mem_wr,
    output logic           wb_valid,
    output logic [AW-1:0]  wb_buf
);
    localparam int CW = (BCW > MPW) ? BCW : MPW;

    dma_state_t    state;
    dma_state_t    nxt;
    logic          have_desc;
    logic          dlast_r;
    logic [AW-1:0] base_r;
    logic          zlp_word;
    logic          fin;
    logic          is_short;
    logic          need_wb;
    logic          drop_desc;

    // outputs and decisions
    always_comb begin
        zlp_word  = rx_last && (rx_lastbytes == 3'd0);
        desc_req  = (state == ST_FETCH);
        desc_load = desc_req && desc_ack;
        mem_wr    = (state == ST_XFER) && rx_valid && !zlp_word;
        rx_pop    = (state == ST_XFER) && rx_valid && (zlp_word || mem_ready);
        wb_valid  = (state == ST_WBACK);
        wb_buf    = base_r;
        fin       = rx_pop && rx_last;
        is_short  = CW'(pkt_total) < CW'(max_pkt);
        need_wb   = mode_bf ? is_short : (upd_each || dlast_r);
        drop_desc = !mode_bf || is_short;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nxt = have_desc ? ST_XFER : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (desc_ack) begin
                    nxt = ST_XFER;
                end
            end
            ST_XFER: begin
                if (fin) begin
                    nxt = need_wb ? ST_WBACK : ST_IDLE;
                end
            end
            ST_WBACK: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_desc <= 1'b0;
            dlast_r   <= 1'b0;
            base_r    <= '0;
        end else if (desc_load) begin
            have_desc <= 1'b1;
            dlast_r   <= desc_last;
            base_r    <= desc_addr;
        end else if (fin && drop_desc) begin
            have_desc <= 1'b0;
        end
    end
endmodule

// File: rtl/out_rx_dma.sv
module out_rx_dma #(
    parameter int AW  = 32,
    parameter int LW  = 8,
    parameter int BCW = 16,
    parameter int MPW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_bufmode,
    input  logic           cfg_upd_each,
    input  logic           cfg_thr_en,
    input  logic [7:0]     cfg_thr_len,
    input  logic [MPW-1:0] cfg_max_pkt,
    output logic           desc_req,
    input  logic           desc_ack,
    input  logic [AW-1:0]  desc_addr,
    input  logic           desc_last,
    input  logic           rx_valid,
    input  logic [31:0]    rx_data,
    input  logic           rx_last,
    input  logic [2:0]     rx_lastbytes,
    input  logic           rx_err,
    input  logic [LW-1:0]  rx_level,
    input  logic           rx_pkt_ready,
    output logic           rx_pop,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ready,
    output logic           wb_valid,
    output logic [AW-1:0]  wb_buf,
    output logic [BCW-1:0] wb_bytes,
    output logic           wb_err,
    output logic           irq
);
    logic           go;
    logic           desc_load;
    logic [BCW-1:0] pkt_total;
    logic [BCW-1:0] acc_bytes;
    logic           err_acc;

    out_rx_dma_gate #(.LW(LW), .TW(8)) u_gate (
        .thr_en       (cfg_thr_en),
        .thr_len      (cfg_thr_len),
        .rx_level     (rx_level),
        .rx_pkt_ready (rx_pkt_ready),
        .go           (go)
    );

    out_rx_dma_fsm #(.AW(AW), .BCW(BCW), .MPW(MPW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_bf      (cfg_bufmode),
        .upd_each     (cfg_upd_each),
        .go           (go),
        .desc_ack     (desc_ack),
        .desc_addr    (desc_addr),
        .desc_last    (desc_last),
        .rx_valid     (rx_valid),
        .rx_last      (rx_last),
        .rx_lastbytes (rx_lastbytes),
        .mem_ready    (mem_ready),
        .pkt_total    (pkt_total),
        .max_pkt      (cfg_max_pkt),
        .desc_req     (desc_req),
        .desc_load    (desc_load),
        .rx_pop       (rx_pop),
        .mem_wr       (mem_wr),
        .wb_valid     (wb_valid),
        .wb_buf       (wb_buf)
    );

    out_rx_dma_acct #(.AW(AW), .BCW(BCW)) u_acct (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (desc_load),
        .load_addr (desc_addr),
        .beat      (rx_pop),
        .beat_last (rx_last),
        .beat_lb   (rx_lastbytes),
        .beat_err  (rx_err),
        .clr       (wb_valid),
        .wr_addr   (mem_addr),
        .acc_bytes (acc_bytes),
        .pkt_total (pkt_total),
        .err_acc   (err_acc)
    );

    always_comb begin
        mem_wdata = rx_data;
        wb_bytes  = acc_bytes;
        wb_err    = err_acc;
        irq       = wb_valid;
    end
endmodule

// File: rtl/out_rx_dma_chk.sv
module out_rx_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_thr_en,
    input logic          desc_req,
    input logic          desc_ack,
    input logic          rx_valid,
    input logic          rx_last,
    input logic [2:0]    rx_lastbytes,
    input logic          rx_pkt_ready,
    input logic          rx_pop,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready,
    input logic          wb_valid
);
    a_r7_whole_packet_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_thr_en && mem_wr) |-> rx_pkt_ready);

    a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r10_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_valid);

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && !desc_ack) |=> desc_req);

    a_r11_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    a_r11_wb_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(rx_pop && rx_last));

    a_r12_zlp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_last && (rx_lastbytes == 3'd0)) |-> !mem_wr);
endmodule

bind out_rx_dma out_rx_dma_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_out_rx_dma.sv
module sim_out_rx_dma;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 8;
    localparam int BCW = 16;
    localparam int MPW = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_bufmode = 1'b0;
    logic           cfg_upd_each = 1'b0;
    logic           cfg_thr_en = 1'b0;
    logic [7:0]     cfg_thr_len = 8'd0;
    logic [MPW-1:0] cfg_max_pkt = 11'd64;
    logic           desc_req;
    logic           desc_ack = 1'b0;
    logic [AW-1:0]  desc_addr;
    logic           desc_last;
    logic           rx_valid;
    logic [31:0]    rx_data;
    logic           rx_last;
    logic [2:0]     rx_lastbytes;
    logic           rx_err;
    logic [LW-1:0]  rx_level;
    logic           rx_pkt_ready;
    logic           rx_pop;
    logic           mem_wr;
    logic [AW-1:0]  mem_addr;
    logic [31:0]    mem_wdata;
    logic           mem_ready = 1'b0;
    logic           wb_valid;
    logic [AW-1:0]  wb_buf;
    logic [BCW-1:0] wb_bytes;
    logic           wb_err;
    logic           irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // FIFO model
    logic [31:0] fd [0:255];
    logic        fl [0:255];
    logic        fe [0:255];
    logic [2:0]  fb [0:255];
    int wp = 0, rp = 0, pk_in = 0, pk_out = 0;

    // descriptor table
    logic [AW-1:0] dt_addr [0:63];
    logic          dt_last [0:63];
    int dptr = 0;

    // expected writes and writebacks
    logic [AW-1:0] ew_addr [0:4095];
    logic [31:0]   ew_data [0:4095];
    int eh = 0, et = 0;
    logic [AW-1:0]  eb_buf [0:1023];
    logic [BCW-1:0] eb_bytes [0:1023];
    logic           eb_err [0:1023];
    int bh = 0, bt = 0;
    int n_wr = 0;
    int rdy_mode = 0;

    // reference model state
    bit m_have = 0, m_dlast = 0, m_err = 0;
    logic [AW-1:0] m_addr = '0, m_base = '0;
    int m_acc = 0, m_di = 0;

    assign rx_valid     = (wp != rp);
    assign rx_data      = fd[rp[7:0]];
    assign rx_last      = fl[rp[7:0]];
    assign rx_err       = fe[rp[7:0]];
    assign rx_lastbytes = fb[rp[7:0]];
    assign rx_level     = LW'(wp - rp);
    assign rx_pkt_ready = (pk_in != pk_out);
    assign desc_addr    = dt_addr[dptr[5:0]];
    assign desc_last    = dt_last[dptr[5:0]];

    out_rx_dma #(.AW(AW), .LW(LW), .BCW(BCW), .MPW(MPW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // responders: advance at the edge, drive 1 time unit later
    always @(posedge clk) begin
        if (!rst_n) begin
            dptr <= 0; rp <= 0; pk_out <= 0;
        end else begin
            if (desc_req && desc_ack) dptr <= dptr + 1;
            if (rx_pop) begin
                rp <= rp + 1;
                if (fl[rp[7:0]]) pk_out <= pk_out + 1;
            end
        end
        #1;
        desc_ack  <= ($urandom_range(0, 2) == 0);
        mem_ready <= (rdy_mode == 1) ? 1'b1 : ($urandom_range(0, 3) != 0);
    end

    // monitor away from the active edge
    bit prev_stall = 0, prev_wb = 0;
    logic [AW-1:0] prev_addr;
    logic [31:0]   prev_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(mem_wr && mem_addr == prev_addr && mem_wdata == prev_data,
                    "R10 stall hold", {32'h0, mem_addr}, {32'h0, prev_addr});
            if (mem_wr && mem_ready) begin
                if (eh == et) chk(0, "R2 unexpected write", mem_addr, 0);
                else begin
                    chk(mem_addr == ew_addr[eh[11:0]], "R2 write addr", mem_addr, ew_addr[eh[11:0]]);
                    chk(mem_wdata == ew_data[eh[11:0]], "R10 write data", mem_wdata, ew_data[eh[11:0]]);
                    eh++;
                end
                n_wr++;
            end
            if (wb_valid) begin
                chk(!prev_wb, "R11 wb single pulse", 1, 0);
                chk(irq == 1'b1, "R3 irq with writeback", irq, 1);
                if (bh == bt) chk(0, "R6 unexpected writeback", wb_bytes, 0);
                else begin
                    chk(wb_bytes == eb_bytes[bh[9:0]], "R4 wb bytes", wb_bytes, eb_bytes[bh[9:0]]);
                    chk(wb_buf == eb_buf[bh[9:0]], "R3 wb buffer", wb_buf, eb_buf[bh[9:0]]);
                    chk(wb_err == eb_err[bh[9:0]], "R9 wb error", wb_err, eb_err[bh[9:0]]);
                    bh++;
                end
            end else begin
                chk(irq == 1'b0, "R3 irq idle", irq, 0);
            end
            prev_stall = mem_wr && !mem_ready;
            prev_addr  = mem_addr;
            prev_data  = mem_wdata;
            prev_wb    = wb_valid;
        end else begin
            prev_stall = 0;
            prev_wb = 0;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic restart(input bit bf, input bit upd, input bit thr, input int thl, input int mp);
        rst_n = 1'b0;
        cfg_bufmode = bf; cfg_upd_each = upd; cfg_thr_en = thr;
        cfg_thr_len = 8'(thl); cfg_max_pkt = MPW'(mp);
        wp = 0; pk_in = 0;
        m_have = 0; m_acc = 0; m_err = 0; m_di = 0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
    endtask

    task automatic push_word(input logic [31:0] d, input bit last, input bit e, input logic [2:0] lb);
        while (wp - rp > 200) wait_cycles(1);
        fd[wp[7:0]] = d; fl[wp[7:0]] = last; fe[wp[7:0]] = e; fb[wp[7:0]] = lb;
        wp++;
        if (last) pk_in++;
    endtask

    // mode: 0 plain, 1 expect no early start (R7), 2 expect early start (R8)
    task automatic send_pkt(input int nbytes, input bit e, input int split, input int mode);
        logic [31:0] w [0:15];
        int nw, base_wr, base_rp;
        bit shrt, do_wb;
        logic [2:0] lb;
        nw = (nbytes == 0) ? 1 : (nbytes + 3) / 4;
        lb = (nbytes == 0) ? 3'd0 : 3'(((nbytes - 1) % 4) + 1);
        for (int i = 0; i < nw; i++) w[i] = $urandom;
        if (!m_have) begin
            m_addr = dt_addr[m_di[5:0]]; m_base = m_addr;
            m_dlast = dt_last[m_di[5:0]]; m_di++; m_have = 1;
        end
        if (nbytes > 0) begin
            for (int i = 0; i < nw; i++) begin
                ew_addr[et[11:0]] = m_addr; ew_data[et[11:0]] = w[i]; et++;
                m_addr += 4;
            end
        end
        m_acc += nbytes;
        m_err |= e;
        shrt  = (nbytes < int'(cfg_max_pkt));
        do_wb = cfg_bufmode ? shrt : (cfg_upd_each || m_dlast);
        if (do_wb) begin
            eb_buf[bt[9:0]] = m_base; eb_bytes[bt[9:0]] = BCW'(m_acc);
            eb_err[bt[9:0]] = m_err; bt++;
            m_acc = 0; m_err = 0;
        end
        if (!cfg_bufmode || shrt) m_have = 0;
        for (int i = 0; i < nw; i++) begin
            push_word(w[i], i == nw - 1, (i == nw - 1) && e, (i == nw - 1) ? lb : 3'd0);
            if (split > 0 && i == split - 1 && nw > split) begin
                base_wr = n_wr; base_rp = rp;
                wait_cycles(30);
                if (mode == 1) begin
                    chk(n_wr == base_wr, "R7 no write before whole packet", n_wr - base_wr, 0);
                    chk(rp == base_rp, "R7 no pop before whole packet", rp - base_rp, 0);
                end else if (mode == 2) begin
                    chk(n_wr > base_wr, "R8 early start writes", n_wr - base_wr, 1);
                end
            end
        end
    endtask

    task automatic drain_and_check(input string tag);
        int guard = 0;
        while ((wp != rp || eh != et) && guard < 4000) begin
            wait_cycles(1); guard++;
        end
        wait_cycles(8);
        chk(eh == et, {tag, " all writes seen"}, eh, et);
        chk(bh == bt, {tag, " all writebacks seen"}, bh, bt);
    endtask

    task automatic fill_desc(input int last_every);
        for (int i = 0; i < 64; i++) begin
            dt_addr[i] = 32'h1000_0000 + 32'(i) * 32'h400 + 32'(($urandom_range(0, 15)) * 4);
            dt_last[i] = (last_every == 0) ? 1'b0 : ((i % last_every) == last_every - 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        fill_desc(1);
        // R1: reset state
        restart(0, 1, 0, 0, 64);
        chk(!desc_req && !mem_wr && !rx_pop && !wb_valid && !irq, "R1 quiet after reset",
            {desc_req, mem_wr, rx_pop, wb_valid, irq}, 0);
        wait_cycles(10);
        chk(!desc_req && !mem_wr && !rx_pop && !wb_valid && !irq, "R1 quiet with empty FIFO",
            {desc_req, mem_wr, rx_pop, wb_valid, irq}, 0);

        // R2 R3 R12: per packet, update each, stalls
        send_pkt(0, 0, 0, 0);   // R12 zero-length
        send_pkt(1, 0, 0, 0);
        send_pkt(64, 0, 0, 0);
        send_pkt(7, 0, 0, 0);
        for (int i = 0; i < 16; i++) send_pkt($urandom_range(0, 64), 0, 0, 0);
        drain_and_check("R3");

        // R4: end of chain only, chains of 3
        fill_desc(3);
        restart(0, 0, 0, 0, 64);
        for (int i = 0; i < 12; i++) send_pkt($urandom_range(0, 64), 0, 0, 0);
        drain_and_check("R4");

        // R5 R6: fill mode
        fill_desc(0);
        restart(1, 0, 0, 0, 64);
        rdy_mode = 1;
        send_pkt(64, 0, 0, 0); send_pkt(64, 0, 0, 0); send_pkt(17, 0, 0, 0);
        send_pkt(64, 0, 0, 0); send_pkt(0, 0, 0, 0);    // R6 zero-length closes
        send_pkt(3, 0, 0, 0);
        rdy_mode = 0;
        for (int i = 0; i < 10; i++) send_pkt(($urandom_range(0, 1) == 0) ? 64 : $urandom_range(0, 63), 0, 0, 0);
        send_pkt(5, 0, 0, 0);
        drain_and_check("R5");

        // R7: no early start
        fill_desc(1);
        restart(0, 1, 0, 4, 64);
        send_pkt(64, 0, 8, 1);
        drain_and_check("R7");

        // R8 R9: early start, error tail
        restart(0, 1, 1, 4, 64);
        send_pkt(64, 0, 8, 2);
        send_pkt(40, 1, 6, 2);
        send_pkt(20, 0, 0, 0);
        drain_and_check("R8");

        // R9: sticky error across fill buffer
        restart(1, 0, 1, 2, 32);
        send_pkt(32, 1, 4, 2); send_pkt(32, 0, 0, 0); send_pkt(9, 0, 0, 0);
        drain_and_check("R9");

        // mixed random
        for (int s = 0; s < 6; s++) begin
            fill_desc($urandom_range(1, 4));
            restart($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(1, 12), 64);
            for (int i = 0; i < 14; i++)
                send_pkt($urandom_range(0, 64), $urandom_range(0, 7) == 0, 0, 0);
            send_pkt(2, 0, 0, 0);
            drain_and_check("R2 random");
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("[TB] FAIL R11 watchdog expired: actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule